// File: doc/BRIEF.md
# DMA Channel Request Controller

This block holds the programming state of a set of DMA channels and arbitrates single transfer requests from devices against that state. Software programs each channel through a 32-bit register bus: a base word, a mode word that enables the channel and selects its direction, a remaining byte count and a start address. Eight register sets exist. Only the lower four can be named by a transfer request; the upper four are plain storage.

A device asks for a transfer by giving a channel number, the direction it wants and a byte length. The controller first wipes the channel's three status bits. It then checks that the channel is enabled and that the requested direction matches the channel's direction bit. On a match it grants the transfer. It puts out the channel's start address and a length clamped to the remaining count, lowers the count by that length and marks terminal count. On a mismatch it refuses the transfer, marks a memory error in the mode word and latches the channel's bit in a sticky interrupt-source register. Moving the data and translating addresses happen elsewhere.

The request path is a two-state machine. `ST_IDLE` accepts a request; the *accept* transition to `ST_EVAL` happens when `req_valid` is seen. `ST_EVAL` makes the decision; the *finish* transition back to `ST_IDLE` is unconditional.

Top module: `dmac_ctrl`

## Requirements
- R1: After reset every channel register word reads zero and the interrupt-source register (byte offset 0x200) reads zero.
- R2: Word k (0 base, 1 mode, 2 count, 3 address) of register set s sits at byte offset 0x100 + 32*s + 8*k. It is read/write for all eight sets and a write is read back unchanged.
- R3: A read of any offset that is not a channel word or 0x200 returns zero. A write to such an offset changes no register. Accesses are whole 32-bit words.
- R4: Mode word bits: bit 0 enables the channel, and bit 1 set means memory-to-device (clear means device-to-memory). Bit 8 is terminal count, bit 9 is memory error and bit 10 is address error.
- R5: When a request is accepted, bits 8, 9 and 10 of the named channel's mode word are cleared before the decision. The other mode bits are left alone.
- R6: A request to a channel whose enable bit is clear is refused. `reject_valid` pulses, no grant is issued, mode bit 9 is set, bit n of the interrupt-source register is set, and count and address are unchanged.
- R7: A request whose direction (`req_to_mem`=1 for device-to-memory) disagrees with mode bit 1 is refused in the same way as R6.
- R8: A granted transfer presents the channel's address register on `grant_addr` and the smaller of `req_len` and the remaining count on `grant_len`. The address register is not advanced.
- R9: After a grant, mode bit 8 is set and the count register is reduced by the granted length.
- R10: A request is accepted on a clock edge where `req_ready` and `req_valid` are both high. `req_ready` is low for the next cycle. Exactly one of `grant_valid` or `reject_valid` is high for one cycle, starting one clock after acceptance.
- R11: Interrupt-source bits are set only by refusals. Writes to 0x200 are ignored, and only reset clears the bits.
- R12: A request to an enabled, matching channel with zero remaining count is granted with length zero, and bit 8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Transfer request present |
| req_ch | input | 2 | Requesting channel |
| req_to_mem | input | 1 | 1 = device-to-memory, 0 = memory-to-device |
| req_len | input | 32 | Requested byte length |
| req_ready | output | 1 | Controller can accept a request |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_addr | output | 32 | Start address of the granted transfer |
| grant_len | output | 32 | Granted byte length |
| reject_valid | output | 1 | One-cycle refusal pulse |

## Verification
The hardest state to reach is a request that finds stale status bits. This needs bits 9 and 10 already set, along with a direction match, and bit 10 is never set by the block itself. The bench writes a mode word with both error bits set through the register bus and then issues a matching request. It expects only bit 8 to remain afterwards. It reaches clamping the same way: it drains a channel with successive grants until the count is below the request and then zero, and checks both the clamped and the zero-length grants.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } dmac_state_e;

    // Mode word bit positions
    localparam int MODE_EN   = 0;
    localparam int MODE_M2D  = 1;
    localparam int MODE_TC   = 8;
    localparam int MODE_MERR = 9;
    localparam int MODE_AERR = 10;

    // Word index inside a register set
    localparam int W_BASE = 0;
    localparam int W_MODE = 1;
    localparam int W_CNT  = 2;
    localparam int W_ADDR = 3;
    localparam int WORDS_PER_SET = 4;

endpackage

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int NUM_XFER = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 10,
    parameter int SET_OFF  = 'h100,
    parameter int SRC_OFF  = 'h200,
    localparam int CH_W    = $clog2(NUM_XFER),
    localparam int NWORDS  = NUM_SETS * WORDS_PER_SET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CH_W-1:0]   eng_ch,
    input  logic              eng_clr,
    input  logic              eng_tc,
    input  logic              eng_merr,
    input  logic [DATA_W-1:0] eng_dec_len,
    output logic              sel_en,
    output logic              sel_m2d,
    output logic [DATA_W-1:0] sel_count,
    output logic [DATA_W-1:0] sel_addr
);

    logic [NWORDS-1:0]   hit;
    logic [DATA_W-1:0]   word_q [NWORDS];
    logic [NUM_XFER-1:0] irq_src;
    logic                src_hit;

    assign src_hit = (bus_addr == ADDR_W'(SRC_OFF));

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar w = 0; w < WORDS_PER_SET; w++) begin : g_word
            localparam logic [ADDR_W-1:0] OFF = ADDR_W'(SET_OFF + s*32 + w*8);
            logic [DATA_W-1:0] q;
            assign hit[s*WORDS_PER_SET + w]    = (bus_addr == OFF);
            assign word_q[s*WORDS_PER_SET + w] = q;

            if (s < NUM_XFER && w == W_MODE) begin : g_mode
                logic here;
                assign here = (eng_ch == CH_W'(s));
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        q <= '0;
                    end else if (here && eng_clr) begin
                        q[MODE_TC]   <= 1'b0;
                        q[MODE_MERR] <= 1'b0;
                        q[MODE_AERR] <= 1'b0;
                    end else if (here && eng_tc) begin
                        q[MODE_TC] <= 1'b1;
                    end else if (here && eng_merr) begin
                        q[MODE_MERR] <= 1'b1;
                    end else if (bus_wr && hit[s*WORDS_PER_SET + w]) begin
                        q <= bus_wdata;
                    end
                end
            end else if (s < NUM_XFER && w == W_CNT) begin : g_cnt
                logic here;
                assign here = (eng_ch == CH_W'(s));
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        q <= '0;
                    end else if (here && eng_tc) begin
                        q <= q - eng_dec_len;
                    end else if (bus_wr && hit[s*WORDS_PER_SET + w]) begin
                        q <= bus_wdata;
                    end
                end
            end else begin : g_plain
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        q <= '0;
                    end else if (bus_wr && hit[s*WORDS_PER_SET + w]) begin
                        q <= bus_wdata;
                    end
                end
            end
        end
    end

    // Sticky refusal record, cleared by reset only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_src <= '0;
        end else if (eng_merr) begin
            irq_src[eng_ch] <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (hit[i]) bus_rdata = word_q[i];
        end
        if (src_hit) bus_rdata = DATA_W'(irq_src);
    end

    always_comb begin
        sel_en    = 1'b0;
        sel_m2d   = 1'b0;
        sel_count = '0;
        sel_addr  = '0;
        for (int c = 0; c < NUM_XFER; c++) begin
            if (eng_ch == CH_W'(c)) begin
                sel_en    = word_q[c*WORDS_PER_SET + W_MODE][MODE_EN];
                sel_m2d   = word_q[c*WORDS_PER_SET + W_MODE][MODE_M2D];
                sel_count = word_q[c*WORDS_PER_SET + W_CNT];
                sel_addr  = word_q[c*WORDS_PER_SET + W_ADDR];
            end
        end
    end

    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_src & $past(irq_src)) == $past(irq_src)));

    assert_irq_needs_refusal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_merr |=> (irq_src == $past(irq_src)));

endmodule

// File: rtl/dmac_req_fsm.sv
module dmac_req_fsm
    import dmac_pkg::*;
#(
    parameter int NUM_XFER = 4,
    parameter int DATA_W   = 32,
    localparam int CH_W    = $clog2(NUM_XFER)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_ch,
    input  logic              req_to_mem,
    input  logic [DATA_W-1:0] req_len,
    output logic              req_ready,
    input  logic              sel_en,
    input  logic              sel_m2d,
    input  logic [DATA_W-1:0] sel_count,
    input  logic [DATA_W-1:0] sel_addr,
    output logic [CH_W-1:0]   eng_ch,
    output logic              eng_clr,
    output logic              eng_tc,
    output logic              eng_merr,
    output logic [DATA_W-1:0] eng_dec_len,
    output logic              grant_valid,
    output logic [DATA_W-1:0] grant_addr,
    output logic [DATA_W-1:0] grant_len,
    output logic              reject_valid
);

    dmac_state_e       state, state_nxt;
    logic [CH_W-1:0]   cur_ch;
    logic              cur_to_mem;
    logic [DATA_W-1:0] cur_len;
    logic              consistent;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nxt = ST_EVAL;   // accept
            ST_EVAL: state_nxt = ST_IDLE;                  // finish
        endcase
    end

    // Direction bit set means memory-to-device; request to_mem must be its inverse
    assign consistent  = sel_en && (cur_to_mem != sel_m2d);
    assign req_ready   = (state == ST_IDLE);
    assign eng_ch      = (state == ST_IDLE) ? req_ch : cur_ch;
    assign eng_clr     = (state == ST_IDLE) && req_valid;
    assign eng_tc      = (state == ST_EVAL) && consistent;
    assign eng_merr    = (state == ST_EVAL) && !consistent;
    assign eng_dec_len = (cur_len < sel_count) ? cur_len : sel_count;

    // Outputs and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch       <= '0;
            cur_to_mem   <= 1'b0;
            cur_len      <= '0;
            grant_valid  <= 1'b0;
            grant_addr   <= '0;
            grant_len    <= '0;
            reject_valid <= 1'b0;
        end else begin
            if (eng_clr) begin
                cur_ch     <= req_ch;
                cur_to_mem <= req_to_mem;
                cur_len    <= req_len;
            end
            grant_valid  <= eng_tc;
            reject_valid <= eng_merr;
            if (eng_tc) begin
                grant_addr <= sel_addr;
                grant_len  <= eng_dec_len;
            end
        end
    end

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && reject_valid));

    assert_outcome_follows_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid || reject_valid) |-> $past(req_valid && req_ready, 2));

    assert_ready_after_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid || reject_valid) |-> req_ready);

    assert_grant_clamped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_len <= $past(sel_count)));

endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int NUM_XFER = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 10,
    localparam int CH_W    = $clog2(NUM_XFER)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_ch,
    input  logic              req_to_mem,
    input  logic [DATA_W-1:0] req_len,
    output logic              req_ready,
    output logic              grant_valid,
    output logic [DATA_W-1:0] grant_addr,
    output logic [DATA_W-1:0] grant_len,
    output logic              reject_valid
);

    logic [CH_W-1:0]   eng_ch;
    logic              eng_clr, eng_tc, eng_merr;
    logic [DATA_W-1:0] eng_dec_len;
    logic              sel_en, sel_m2d;
    logic [DATA_W-1:0] sel_count, sel_addr;

    dmac_regfile #(
        .NUM_SETS(NUM_SETS), .NUM_XFER(NUM_XFER),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(reg_wr), .bus_addr(reg_addr),
        .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
        .eng_ch(eng_ch), .eng_clr(eng_clr), .eng_tc(eng_tc),
        .eng_merr(eng_merr), .eng_dec_len(eng_dec_len),
        .sel_en(sel_en), .sel_m2d(sel_m2d),
        .sel_count(sel_count), .sel_addr(sel_addr)
    );

    dmac_req_fsm #(
        .NUM_XFER(NUM_XFER), .DATA_W(DATA_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ch(req_ch),
        .req_to_mem(req_to_mem), .req_len(req_len),
        .req_ready(req_ready),
        .sel_en(sel_en), .sel_m2d(sel_m2d),
        .sel_count(sel_count), .sel_addr(sel_addr),
        .eng_ch(eng_ch), .eng_clr(eng_clr), .eng_tc(eng_tc),
        .eng_merr(eng_merr), .eng_dec_len(eng_dec_len),
        .grant_valid(grant_valid), .grant_addr(grant_addr),
        .grant_len(grant_len), .reject_valid(reject_valid)
    );

endmodule

// File: tb/tb_dmac_ctrl.sv
module tb_dmac_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [1:0]  req_ch = '0;
    logic        req_to_mem = 1'b0;
    logic [31:0] req_len = '0;
    logic        req_ready, grant_valid, reject_valid;
    logic [31:0] grant_addr, grant_len;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ch(req_ch),
        .req_to_mem(req_to_mem), .req_len(req_len),
        .req_ready(req_ready), .grant_valid(grant_valid),
        .grant_addr(grant_addr), .grant_len(grant_len),
        .reject_valid(reject_valid)
    );

    function automatic logic [9:0] woff(int s, int w);
        return 10'(32'h100 + s*32 + w*8);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Issues one request and checks the handshake timing (R10)
    task automatic do_req(logic [1:0] ch, logic to_mem, logic [31:0] len,
                          output logic g, output logic r,
                          output logic [31:0] ga, output logic [31:0] gl);
        @(negedge clk);
        check("R10", "ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_ch = ch; req_to_mem = to_mem; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", "ready while deciding", {31'd0, req_ready}, 32'd0);
        check("R10", "no early outcome", {30'd0, grant_valid, reject_valid}, 32'd0);
        @(negedge clk);
        g = grant_valid; r = reject_valid; ga = grant_addr; gl = grant_len;
        check("R10", "exactly one outcome", {31'd0, g ^ r}, 32'd1);
        @(negedge clk);
        check("R10", "outcome is one cycle", {30'd0, grant_valid, reject_valid}, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++) begin
                rd(woff(s, w), d);
                check("R1", $sformatf("set %0d word %0d after reset", s, w), d, 32'd0);
            end
        rd(10'h200, d);
        check("R1", "interrupt source after reset", d, 32'd0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++)
                wr(woff(s, w), 32'hA500_0005 | 32'(s << 8) | 32'(w << 4));
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++) begin
                rd(woff(s, w), d);
                check("R2", $sformatf("set %0d word %0d readback", s, w), d,
                      32'hA500_0005 | 32'(s << 8) | 32'(w << 4));
            end
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(10'h104, 32'hDEAD_BEEF);
        wr(10'h000, 32'h1234_5678);
        wr(10'h300, 32'hFFFF_FFFF);
        rd(10'h104, d); check("R3", "read between words", d, 32'd0);
        rd(10'h000, d); check("R3", "read below map", d, 32'd0);
        rd(10'h300, d); check("R3", "read above map", d, 32'd0);
        rd(10'h208, d); check("R3", "read near source reg", d, 32'd0);
        rd(woff(0, 0), d); check("R3", "neighbour word untouched", d, 32'hA500_0005);
        rd(woff(0, 1), d); check("R3", "next word untouched", d, 32'hA500_0015);
    endtask

    task automatic t_grant();
        logic g, r; logic [31:0] ga, gl, d;
        wr(woff(1, 1), 32'h0000_0003);   // enable, memory-to-device
        wr(woff(1, 2), 32'd100);
        wr(woff(1, 3), 32'h0000_8000);
        do_req(2'd1, 1'b0, 32'd40, g, r, ga, gl);
        check("R8", "grant issued", {31'd0, g}, 32'd1);
        check("R8", "grant address", ga, 32'h0000_8000);
        check("R8", "grant length unclamped", gl, 32'd40);
        rd(woff(1, 1), d); check("R9", "mode after grant", d, 32'h0000_0103);
        rd(woff(1, 2), d); check("R9", "count after grant", d, 32'd60);
        rd(woff(1, 3), d); check("R8", "address not advanced", d, 32'h0000_8000);
        do_req(2'd1, 1'b0, 32'd100, g, r, ga, gl);
        check("R8", "clamped grant length", gl, 32'd60);
        rd(woff(1, 2), d); check("R9", "count drained", d, 32'd0);
        do_req(2'd1, 1'b0, 32'd5, g, r, ga, gl);
        check("R12", "zero-count grant", {31'd0, g}, 32'd1);
        check("R12", "zero-count length", gl, 32'd0);
        rd(woff(1, 1), d); check("R12", "tc set on zero grant", d, 32'h0000_0103);
    endtask

    task automatic t_status_clear();
        logic g, r; logic [31:0] ga, gl, d;
        wr(woff(2, 1), 32'h0000_0701);   // enable, device-to-memory, stale status
        wr(woff(2, 2), 32'd10);
        wr(woff(2, 3), 32'h0000_0040);
        do_req(2'd2, 1'b1, 32'd4, g, r, ga, gl);
        check("R5", "stale status request granted", {31'd0, g}, 32'd1);
        rd(woff(2, 1), d); check("R5", "bits 9 and 10 wiped", d, 32'h0000_0101);
        rd(woff(2, 2), d); check("R9", "count reduced", d, 32'd6);
    endtask

    task automatic t_reject_disabled();
        logic g, r; logic [31:0] ga, gl, d;
        wr(woff(3, 1), 32'h0000_0100);   // disabled, stale tc
        wr(woff(3, 2), 32'd20);
        wr(woff(3, 3), 32'h0000_0900);
        do_req(2'd3, 1'b1, 32'd4, g, r, ga, gl);
        check("R6", "disabled channel refused", {30'd0, g, r}, 32'd1);
        rd(woff(3, 1), d); check("R6", "mode after refusal", d, 32'h0000_0200);
        rd(woff(3, 2), d); check("R6", "count unchanged", d, 32'd20);
        rd(woff(3, 3), d); check("R6", "address unchanged", d, 32'h0000_0900);
        rd(10'h200, d);    check("R6", "source bit 3", d, 32'h0000_0008);
    endtask

    task automatic t_reject_dir();
        logic g, r; logic [31:0] ga, gl, d;
        wr(woff(0, 1), 32'h0000_0001);   // enable, device-to-memory
        wr(woff(0, 2), 32'd8);
        wr(woff(0, 3), 32'h0000_0200);
        do_req(2'd0, 1'b0, 32'd4, g, r, ga, gl);
        check("R7", "direction mismatch refused", {30'd0, g, r}, 32'd1);
        rd(woff(0, 1), d); check("R7", "mode after mismatch", d, 32'h0000_0201);
        rd(woff(0, 2), d); check("R7", "count unchanged", d, 32'd8);
        rd(10'h200, d);    check("R7", "source bits 0 and 3", d, 32'h0000_0009);
        do_req(2'd0, 1'b1, 32'd4, g, r, ga, gl);
        check("R4", "matching direction granted", {30'd0, g, r}, 32'd2);
        rd(woff(0, 1), d); check("R5", "error bit cleared by new request", d, 32'h0000_0101);
        rd(10'h200, d);    check("R11", "source survives grant", d, 32'h0000_0009);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        wr(10'h200, 32'h0000_0000);
        rd(10'h200, d); check("R11", "write of zero ignored", d, 32'h0000_0009);
        wr(10'h200, 32'h0000_000F);
        rd(10'h200, d); check("R11", "write of ones ignored", d, 32'h0000_0009);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(10'h200, d);    check("R11", "reset clears source", d, 32'd0);
        rd(woff(1, 2), d); check("R1", "reset clears channel word", d, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_unmapped();
        t_grant();
        t_status_clear();
        t_reject_disabled();
        t_reject_dir();
        t_sticky();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule